// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between four interrupt request lines and a small processor core. Each line has its own enable bit in a register that software can rewrite at any time. A global enable input gates all four. The block latches each new request and picks the highest-ranked candidate that is both pending and enabled. Source 0 ranks lowest and source 3 ranks highest. When a candidate is accepted, the block raises a one-cycle accept pulse with the source index and a vector. At the same moment it raises a strobe that tells the core to push its return address.

The block records which levels are currently in service. A request can interrupt a running handler only if it ranks above every level in service, so a handler can be preempted by stronger sources and never by weaker or equal ones. A return strobe from the core ends the most recent level. Requests that were held back are then reconsidered on the following clock. Software can change the effective priority order by clearing enable bits inside a handler.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset the accept pulse is low, no level is in service, nothing is pending and the enable register reads 0.
- R2: A request is latched as pending on its rising edge (low in one sampled cycle, high in the next). A request held high after its acceptance does not become pending again.
- R3: A source whose enable bit is 0 is never accepted. Its pending bit stays set and is visible on `pend_o`.
- R4: When several enabled sources are pending and none is in service, the source with the highest index (3 highest, 0 lowest) is accepted first.
- R5: A pending, enabled source with an index above every in-service level is accepted while the lower handler runs. Both levels then show as set on `insvc_o`, with bit i standing for source i.
- R6: A source whose index is equal to or below the highest in-service level is not accepted. It stays pending.
- R7: While `gie_i` is low no source is accepted, and pending bits are kept. Acceptance follows once `gie_i` returns high.
- R8: Each acceptance raises `acc_o` and `push_o` together for exactly one cycle, with `src_o` holding the 2-bit index of the accepted source. The accept pulse appears two clock edges after the rising edge of the request is applied.
- R9: With each accept, `vec_o` equals VEC_BASE + index × VEC_STRIDE (defaults 0x20 and 4).
- R10: A cycle with `ret_i` high clears the highest set in-service bit and accepts nothing. Pending sources that are now eligible are accepted on the next evaluation.
- R11: A cycle with `en_wr_i` high loads `en_wdata_i` into the enable register. The new value is visible on `en_o` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request lines, bit i is source i |
| gie_i | input | 1 | Global acceptance enable |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | N_SRC | Enable register write data |
| ret_i | input | 1 | Return-from-handler strobe |
| acc_o | output | 1 | One-cycle accept pulse |
| push_o | output | 1 | Return-address push strobe, coincident with accept |
| src_o | output | IDX_W | Index of the accepted source |
| vec_o | output | VEC_W | Vector of the accepted source |
| en_o | output | N_SRC | Current enable register |
| pend_o | output | N_SRC | Pending bits |
| insvc_o | output | N_SRC | In-service levels |

## Verification
If the in-service record is wrong, the arbiter accepts something it should not. One case is a source at or below a running level: within two cycles the accept pulse comes with an index that is not above the levels shown. The other case is a return that clears the wrong level: the next accept goes to the wrong source, or none comes when one should. A lost or duplicated pending bit shows up as a missing accept or an extra one. It can also show as a stale bit on `pend_o` a few cycles after the request edge. A missed or doubled accept pulse is counted directly against the number of requests driven. The sweeps visit every ordered pair of sources and every enable mask, so a fault in any compare of the ranking surfaces within a few cycles of the pattern that reaches it.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   localparam int unsigned MAX_SRC = 32;

   // index of highest set bit, 0 when none is set
   function automatic int unsigned top_bit(input logic [MAX_SRC-1:0] v);
      int unsigned r;
      r = 0;
      for (int unsigned i = 0; i < MAX_SRC; i++) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int unsigned N_SRC     = 4,
   parameter bit          PEND_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o
);

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_src
         logic pend_q;
         if (PEND_EDGE) begin : g_edge
            logic req_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  req_q  <= 1'b0;
                  pend_q <= 1'b0;
               end else begin
                  req_q  <= req_i[g];
                  pend_q <= (pend_q & ~clr_i[g]) | (req_i[g] & ~req_q);
               end
            end
         end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pend_q <= 1'b0;
               else        pend_q <= (pend_q & ~clr_i[g]) | req_i[g];
            end
         end
         assign pend_o[g] = pend_q;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_nest_pkg::*;
#(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] cand_i,
   input  logic [N_SRC-1:0] insvc_i,
   input  logic             gie_i,
   input  logic             block_i,
   output logic             take_o,
   output logic [IDX_W-1:0] idx_o
);

   logic [IDX_W-1:0] hi_cand;
   logic [IDX_W-1:0] hi_svc;

   always_comb begin
      hi_cand = IDX_W'(top_bit(MAX_SRC'(cand_i)));
      hi_svc  = IDX_W'(top_bit(MAX_SRC'(insvc_i)));
   end

   assign take_o = gie_i & ~block_i & (|cand_i) &
                   (~(|insvc_i) | (hi_cand > hi_svc));
   assign idx_o  = hi_cand;

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
   import irq_nest_pkg::*;
#(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [IDX_W-1:0] set_idx_i,
   input  logic             ret_i,
   output logic [N_SRC-1:0] insvc_o
);

   logic [N_SRC-1:0] svc_q;
   logic [N_SRC-1:0] svc_d;
   logic [IDX_W-1:0] top;

   always_comb begin
      top   = IDX_W'(top_bit(MAX_SRC'(svc_q)));
      svc_d = svc_q;
      if (set_i)                   svc_d[set_idx_i] = 1'b1;
      else if (ret_i && |svc_q)    svc_d[top]       = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_q <= '0;
      else        svc_q <= svc_d;
   end

   assign insvc_o = svc_q;

endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb #(
   parameter int unsigned N_SRC      = 4,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 32,
   parameter int unsigned VEC_STRIDE = 4,
   parameter bit          PEND_EDGE  = 1'b1,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   input  logic             gie_i,
   input  logic             en_wr_i,
   input  logic [N_SRC-1:0] en_wdata_i,
   input  logic             ret_i,
   output logic             acc_o,
   output logic             push_o,
   output logic [IDX_W-1:0] src_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [N_SRC-1:0] en_o,
   output logic [N_SRC-1:0] pend_o,
   output logic [N_SRC-1:0] insvc_o
);

   generate
      if (N_SRC < 2 || N_SRC > 32) begin : g_bad_nsrc
         $error("irq_nest_arb: N_SRC must lie in 2..32");
      end
      if (VEC_W < 2 || VEC_W > 32) begin : g_bad_vecw
         $error("irq_nest_arb: VEC_W must lie in 2..32");
      end
      if (VEC_BASE + (N_SRC - 1) * VEC_STRIDE >= (64'd1 << VEC_W)) begin : g_bad_vec
         $error("irq_nest_arb: vector range exceeds VEC_W");
      end
   endgenerate

   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] cand;
   logic [N_SRC-1:0] clr;
   logic             take;
   logic [IDX_W-1:0] idx;
   logic             acc_q;
   logic [IDX_W-1:0] src_q;
   logic [VEC_W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_wr_i) en_q <= en_wdata_i;
   end

   irq_edge_latch #(.N_SRC(N_SRC), .PEND_EDGE(PEND_EDGE)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   assign cand = pend & en_q;

   irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
      .cand_i  (cand),
      .insvc_i (insvc_o),
      .gie_i   (gie_i),
      .block_i (ret_i),
      .take_o  (take),
      .idx_o   (idx)
   );

   always_comb begin
      clr = '0;
      if (take) clr[idx] = 1'b1;
   end

   irq_svc_track #(.N_SRC(N_SRC)) u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (take),
      .set_idx_i (idx),
      .ret_i     (ret_i),
      .insvc_o   (insvc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
         src_q <= '0;
         vec_q <= '0;
      end else begin
         acc_q <= take;
         if (take) begin
            src_q <= idx;
            vec_q <= VEC_W'(VEC_BASE + 32'(idx) * VEC_STRIDE);
         end
      end
   end

   assign acc_o  = acc_q;
   assign push_o = acc_q;
   assign src_o  = src_q;
   assign vec_o  = vec_q;
   assign en_o   = en_q;
   assign pend_o = pend;

endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gie_i,
   input logic             ret_i,
   input logic             acc_o,
   input logic [IDX_W-1:0] src_o,
   input logic [N_SRC-1:0] en_o,
   input logic [N_SRC-1:0] insvc_o
);

   // R5: the accepted level is recorded in service on the same edge
   a_r5_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> insvc_o[src_o]);

   // R6: no level above the accepted one is in service
   a_r6_none_above: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> ((insvc_o >> src_o) == N_SRC'(1)));

   // R3: the accepted source was enabled when it was chosen
   a_r3_was_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> ((($past(en_o) >> src_o) & N_SRC'(1)) != '0));

   // R7: global enable was high when the choice was made
   a_r7_gie_held: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> $past(gie_i));

   // R10: a return cycle accepts nothing
   a_r10_ret_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> !acc_o);

endmodule

bind irq_nest_arb irq_nest_arb_chk #(.N_SRC(N_SRC)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .gie_i   (gie_i),
   .ret_i   (ret_i),
   .acc_o   (acc_o),
   .src_o   (src_o),
   .en_o    (en_o),
   .insvc_o (insvc_o)
);

// File: tb/test_irq_nest_arb.sv
`timescale 1ns/1ps
module test_irq_nest_arb;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         gie = 1'b0;
   logic         en_wr = 1'b0;
   logic [N-1:0] en_wdata = '0;
   logic         ret = 1'b0;
   logic         acc_o, push_o;
   logic [1:0]   src_o;
   logic [7:0]   vec_o;
   logic [N-1:0] en_o, pend_o, insvc_o;

   int n_chk = 0;
   int n_bad = 0;
   int n_acc = 0;
   int n_push_diff = 0;
   int last_src = 0;
   int last_vec = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_nest_arb i_irq_nest_arb (
      .clk(clk), .rst_n(rst_n), .req_i(req), .gie_i(gie),
      .en_wr_i(en_wr), .en_wdata_i(en_wdata), .ret_i(ret),
      .acc_o(acc_o), .push_o(push_o), .src_o(src_o), .vec_o(vec_o),
      .en_o(en_o), .pend_o(pend_o), .insvc_o(insvc_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (acc_o) begin
            n_acc    <= n_acc + 1;
            last_src <= int'(src_o);
            last_vec <= int'(vec_o);
         end
         if (acc_o !== push_o) n_push_diff <= n_push_diff + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int k);
      repeat (k) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; gie = 1'b0; en_wr = 1'b0; ret = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(1);
      n_acc = 0;
   endtask

   task automatic write_en(input logic [N-1:0] v);
      en_wr = 1'b1; en_wdata = v;
      wait_cyc(1);
      en_wr = 1'b0;
   endtask

   task automatic do_ret();
      ret = 1'b1;
      wait_cyc(1);
      ret = 1'b0;
   endtask

   function automatic int top_of(input int m);
      int r = -1;
      for (int i = 0; i < N; i++) if (m[i]) r = i;
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk(acc_o == 1'b0, "R1 acc", int'(acc_o), 0);
      chk(insvc_o == '0, "R1 insvc", int'(insvc_o), 0);
      chk(pend_o == '0, "R1 pend", int'(pend_o), 0);
      chk(en_o == '0, "R1 en", int'(en_o), 0);

      // R11 enable write
      write_en(4'b1010);
      chk(en_o == 4'b1010, "R11 en write", int'(en_o), 'ha);
      write_en(4'b1111);
      chk(en_o == 4'b1111, "R11 en rewrite", int'(en_o), 'hf);

      // R8 accept latency: rising edge at t, accept after two edges
      gie = 1'b1;
      req[1] = 1'b1;
      wait_cyc(1);
      chk(n_acc == 0, "R8 not before second edge", n_acc, 0);
      wait_cyc(1);
      chk(n_acc == 1 && last_src == 1, "R8 latency", n_acc, 1);
      wait_cyc(3);
      chk(n_acc == 1, "R8 single pulse", n_acc, 1);
      req = '0;

      // pair sweep: first a in service, then b requested
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            do_reset();
            write_en('1);
            gie = 1'b1;
            req[a] = 1'b1;
            wait_cyc(4);
            chk(n_acc == 1 && last_src == a, "R8 first accept src", last_src, a);
            chk(last_vec == 32 + 4 * a, "R9 vector", last_vec, 32 + 4 * a);
            chk(insvc_o == N'(1 << a), "R5 first level", int'(insvc_o), 1 << a);
            chk(pend_o == '0, "R2 held level not repended", int'(pend_o), 0);
            req = '0;
            wait_cyc(1);
            req[b] = 1'b1;
            wait_cyc(4);
            if (b > a) begin
               chk(n_acc == 2 && last_src == b, "R5 preempt", last_src, b);
               chk(insvc_o == N'((1 << a) | (1 << b)), "R5 nested levels",
                   int'(insvc_o), (1 << a) | (1 << b));
            end else begin
               chk(n_acc == 1, "R6 no lower preempt", n_acc, 1);
               chk(pend_o[b] == 1'b1, "R6 stays pending", int'(pend_o), 1 << b);
            end
            do_ret();
            wait_cyc(3);
            if (b > a) begin
               chk(insvc_o == N'(1 << a), "R10 top level cleared", int'(insvc_o), 1 << a);
               chk(n_acc == 2, "R10 no spurious accept", n_acc, 2);
            end else begin
               chk(n_acc == 2 && last_src == b, "R10 held source accepted", last_src, b);
               chk(insvc_o == N'(1 << b), "R10 levels after ret", int'(insvc_o), 1 << b);
            end
            req = '0;
         end
      end

      // enable mask sweep: all four requested together
      for (int m = 0; m < 16; m++) begin
         int rem;
         int exp_n;
         do_reset();
         write_en(N'(m));
         gie = 1'b1;
         req = '1;
         wait_cyc(4);
         exp_n = (m != 0) ? 1 : 0;
         chk(n_acc == exp_n, "R4 first count", n_acc, exp_n);
         if (m != 0) chk(last_src == top_of(m), "R4 highest wins", last_src, top_of(m));
         chk((pend_o & ~N'(m)) == ~N'(m), "R3 disabled stay pending",
             int'(pend_o), int'(~N'(m)));
         rem = m & ~(1 << top_of(m));
         while (rem != 0) begin
            do_ret();
            wait_cyc(3);
            exp_n++;
            chk(n_acc == exp_n && last_src == top_of(rem), "R10 next after ret",
                last_src, top_of(rem));
            rem = rem & ~(1 << top_of(rem));
         end
         do_ret();
         wait_cyc(3);
         chk(n_acc == exp_n, "R3 disabled never accepted", n_acc, exp_n);
         req = '0;
      end

      // R7 global enable
      do_reset();
      write_en('1);
      gie = 1'b0;
      req[2] = 1'b1;
      wait_cyc(4);
      chk(n_acc == 0, "R7 blocked", n_acc, 0);
      chk(pend_o == 4'b0100, "R7 kept pending", int'(pend_o), 4);
      gie = 1'b1;
      wait_cyc(2);
      chk(n_acc == 1 && last_src == 2, "R7 accepted after enable", last_src, 2);
      req = '0;

      chk(n_push_diff == 0, "R8 push with accept", n_push_diff, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule